// File: doc/BRIEF.md
# Programmable 16-bit Interval Timer with Pin Routing

This block is a general-purpose down-counting interval timer for a peripheral subsystem. Software programs a 16-bit period through two byte-wide registers and then steers the timer with one-byte commands written to a control address. Each timeout produces a one-cycle pulse on the timer output. The pulse can also drive general-purpose pin 0. When enabled, a timeout latches a pending interrupt that stays set until software reads the control address.

The count source is either the system clock itself or an external timer clock pin. The pin is brought into the system clock domain through a synchronizer chain, and each rising edge of the synchronized pin counts as one tick, so every flop runs on the single system clock. In retriggerable mode the counter reloads at each timeout and the output pulse rate is the tick rate divided by the period. In single-shot mode it stops after the first timeout. A period of zero keeps the timer from running.

Top module: `tmr16_unit`

## Requirements
- R1: After reset the period reads 0 at both period addresses (address 1 = low byte, address 2 = high byte). The status byte at address 0 reads 0. `irq`, `tmr_out` and `pin0_drive` are 0.
- R2: Reading address 1 or 2 returns the programmed byte, even while the counter is running. Bit 0 of the period is bit 0 of the low byte, and bit 15 is bit 7 of the high byte.
- R3: In retriggerable mode (command 0x6) with the internal clock (command 0x7), a start command (0x1) written at clock edge E0 produces `tmr_out` pulses at edges E0+P, E0+2P, and so on, where P is the period.
- R4: In single-shot mode (command 0x5) the timer produces exactly one pulse, P edges after start, and then status bit 0 (running) reads 0.
- R5: If the period is 0, a start command leaves running at 0 and no pulse occurs.
- R6: A timeout sets the pending interrupt (`irq`, status bit 5) in the cycle of the pulse, but only when interrupts are enabled (command 0x3 enables, 0x4 disables, status bit 1).
- R7: A read of address 0 clears the pending interrupt at that clock edge.
- R8: With routing on (command 0x9, status bit 4), `pin0_drive` pulses together with `tmr_out`. With routing off (command 0xA), `pin0_drive` stays 0.
- R9: With the external clock selected (command 0x8, status bit 3), the counter advances once per rising edge of `ext_clk_pin`. It does not advance while the pin is idle, and it reaches a timeout after P rising edges.
- R10: The reset-timer command (0xB) stops the counter and reloads it from the period. The period registers keep their value. The next start gives its first pulse a full P ticks later.
- R11: The stop command (0x2) halts counting: no pulse occurs while stopped, and status bit 0 reads 0.
- R12: Command codes outside 0x1 to 0xB, written to address 0, leave the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 command/status, 1 period low, 2 period high |
| wdata | input | 8 | Write data; command code in bits 3:0 |
| rdata | output | 8 | Read data, valid while rd_en is high, else 0 |
| ext_clk_pin | input | 1 | External timer clock pin, asynchronous |
| irq | output | 1 | Pending timer interrupt |
| tmr_out | output | 1 | One-cycle timeout pulse |
| pin0_drive | output | 1 | Timeout pulse routed to general-purpose pin 0 |

## Verification
Command and period writes take effect at the clock edge that samples them. Read data is combinational while `rd_en` is high. `tmr_out`, `pin0_drive` and `irq` all become 1 at the edge of the P-th tick, which is P edges after the start write when the internal clock is selected. The bench drives and samples on falling edges. Each write task returns just after its effective edge, and pulse gaps are counted one falling edge per rising edge, so a period of P must give a count of exactly P. Tests with the external clock count whole pulses over a window that extends well past the synchronizer delay, instead of checking exact edge positions.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 2;
    localparam int CMD_W       = 4;
    localparam int SYNC_DEPTH  = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_PLO  = 2'd1,
        A_PHI  = 2'd2
    } addr_e;

    typedef enum logic [CMD_W-1:0] {
        C_START   = 4'h1,
        C_STOP    = 4'h2,
        C_IRQ_EN  = 4'h3,
        C_IRQ_DIS = 4'h4,
        C_SINGLE  = 4'h5,
        C_RETRIG  = 4'h6,
        C_INT_CLK = 4'h7,
        C_EXT_CLK = 4'h8,
        C_ROUTE   = 4'h9,
        C_UNROUTE = 4'hA,
        C_RELOAD  = 4'hB
    } cmd_e;

    typedef struct packed {
        logic route;
        logic ext_sel;
        logic retrig;
        logic irq_en;
    } cfg_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic reload;
        logic clr_pend;
    } ctl_pulse_t;

    function automatic logic [BYTE_W-1:0] pack_status(cfg_t c, logic run, logic pend);
        logic [BYTE_W-1:0] s;
        s    = '0;
        s[0] = run;
        s[1] = c.irq_en;
        s[2] = c.retrig;
        s[3] = c.ext_sel;
        s[4] = c.route;
        s[5] = pend;
        return s;
    endfunction

endpackage

// File: rtl/tmr16_regs.sv
module tmr16_regs
    import tmr16_pkg::*;
#(
    parameter int BW = BYTE_W,
    localparam int PW = 2 * BW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BW-1:0]     wdata,
    output logic [PW-1:0]     period,
    output cfg_t              cfg,
    output ctl_pulse_t        pulse
);

    logic wr_ctrl;
    cmd_e cmd;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign cmd     = cmd_e'(wdata[CMD_W-1:0]);

    always_comb begin
        pulse          = '0;
        pulse.start    = wr_ctrl && (cmd == C_START);
        pulse.stop     = wr_ctrl && (cmd == C_STOP);
        pulse.reload   = wr_ctrl && (cmd == C_RELOAD);
        pulse.clr_pend = rd_en && (addr == A_CTRL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period <= '0;
            cfg    <= '0;
        end else if (wr_en) begin
            case (addr)
                A_PLO:  period[BW-1:0]  <= wdata;
                A_PHI:  period[PW-1:BW] <= wdata;
                A_CTRL: begin
                    case (cmd)
                        C_IRQ_EN:  cfg.irq_en  <= 1'b1;
                        C_IRQ_DIS: cfg.irq_en  <= 1'b0;
                        C_SINGLE:  cfg.retrig  <= 1'b0;
                        C_RETRIG:  cfg.retrig  <= 1'b1;
                        C_INT_CLK: cfg.ext_sel <= 1'b0;
                        C_EXT_CLK: cfg.ext_sel <= 1'b1;
                        C_ROUTE:   cfg.route   <= 1'b1;
                        C_UNROUTE: cfg.route   <= 1'b0;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tmr16_tick.sv
module tmr16_tick
    import tmr16_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_pin,
    input  logic ext_sel,
    output logic tick
);

    logic [STAGES:0] chain;

    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= ext_pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    logic ext_rise;
    assign ext_rise = chain[STAGES-1] & ~chain[STAGES];
    assign tick     = ext_sel ? ext_rise : 1'b1;

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int PW = 2 * BYTE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [PW-1:0] period,
    input  cfg_t          cfg,
    input  ctl_pulse_t    pulse,
    output logic          running,
    output logic          pend,
    output logic          tmr_out,
    output logic          pin_drv
);

    logic [PW-1:0] cnt;
    logic          expire;

    assign expire = running && tick && (cnt <= PW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
            pend    <= 1'b0;
            tmr_out <= 1'b0;
            pin_drv <= 1'b0;
        end else begin
            tmr_out <= 1'b0;
            pin_drv <= 1'b0;
            if (pulse.clr_pend) pend <= 1'b0;
            if (pulse.reload) begin
                running <= 1'b0;
                cnt     <= period;
            end else if (pulse.start) begin
                running <= (period != '0);
                cnt     <= period;
            end else if (pulse.stop) begin
                running <= 1'b0;
            end else if (expire) begin
                cnt     <= period;
                tmr_out <= 1'b1;
                pin_drv <= cfg.route;
                if (cfg.irq_en) pend <= 1'b1;
                if (!cfg.retrig || period == '0) running <= 1'b0;
            end else if (running && tick) begin
                cnt <= cnt - PW'(1);
            end
        end
    end

endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
    import tmr16_pkg::*;
#(
    parameter int BW     = BYTE_W,
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BW-1:0]     wdata,
    output logic [BW-1:0]     rdata,
    input  logic              ext_clk_pin,
    output logic              irq,
    output logic              tmr_out,
    output logic              pin0_drive
);

    localparam int PW = 2 * BW;

    logic [PW-1:0] period;
    cfg_t          cfg;
    ctl_pulse_t    pulse;
    logic          tick;
    logic          running;
    logic          pend;

    tmr16_regs #(.BW(BW)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .period(period), .cfg(cfg), .pulse(pulse)
    );

    tmr16_tick #(.STAGES(STAGES)) tick_i (
        .clk(clk), .rst(rst), .ext_pin(ext_clk_pin), .ext_sel(cfg.ext_sel),
        .tick(tick)
    );

    tmr16_core #(.PW(PW)) core_i (
        .clk(clk), .rst(rst), .tick(tick), .period(period), .cfg(cfg),
        .pulse(pulse), .running(running), .pend(pend), .tmr_out(tmr_out),
        .pin_drv(pin0_drive)
    );

    assign irq = pend;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_CTRL:  rdata = pack_status(cfg, running, pend);
                A_PLO:   rdata = period[BW-1:0];
                A_PHI:   rdata = period[PW-1:BW];
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk
    import tmr16_pkg::*;
#(
    parameter int PW = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq,
    input logic              tmr_out,
    input logic              pin0_drive,
    input logic              running,
    input cfg_t              cfg,
    input logic [PW-1:0]     period,
    input logic              start_p
);

    // R6: a new pending interrupt needs the enable set before the edge
    p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(cfg.irq_en));

    // R7: a control read clears the pending flag unless a timeout hits the same edge
    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_en && addr == A_CTRL) && !tmr_out) |-> !irq);

    // R4: a single-shot timeout leaves the timer stopped
    p_single_stops_r4: assert property (@(posedge clk) disable iff (rst)
        (tmr_out && !$past(cfg.retrig) && !$past(start_p)) |-> !running);

    // R5: the timer never starts with a zero period
    p_nonzero_start_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> ($past(period) != '0));

    // R8: the pin pulse only accompanies a timeout while routing was on
    p_pin_follows_r8: assert property (@(posedge clk) disable iff (rst)
        pin0_drive |-> (tmr_out && $past(cfg.route)));

    // R11: no timeout unless the counter was running
    p_no_idle_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        tmr_out |-> $past(running));

endmodule

bind tmr16_unit tmr16_chk #(.PW(PW)) chk_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .irq(irq),
    .tmr_out(tmr_out), .pin0_drive(pin0_drive), .running(running),
    .cfg(cfg), .period(period), .start_p(pulse.start)
);

// File: tb/tmr16_unit_tb.sv
`timescale 1ns/1ps
module tmr16_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ext_clk_pin = 1'b0;
    logic       irq, tmr_out, pin0_drive;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tmr16_unit dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_clk_pin(ext_clk_pin),
        .irq(irq), .tmr_out(tmr_out), .pin0_drive(pin0_drive)
    );

    localparam logic [15:0] PERIODS [4] = '{16'd1, 16'd3, 16'd7, 16'h0105};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_pulse(input int maxc, output int n);
        n = -1;
        for (int i = 1; i <= maxc; i++) begin
            @(negedge clk);
            if (tmr_out) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic count_pulses(input int cyc, output int n);
        n = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (tmr_out) n++;
        end
    endtask

    task automatic ext_train(input int edges, output int n);
        n = 0;
        for (int e = 0; e < edges; e++) begin
            for (int h = 0; h < 6; h++) begin
                @(negedge clk);
                ext_clk_pin = (h < 3);
                if (tmr_out) n++;
            end
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ext_clk_pin = 1'b0;
            if (tmr_out) n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d, s0, s1;
        int n;

        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        chk("R1 tmr_out", int'(tmr_out), 0);
        chk("R1 pin0", int'(pin0_drive), 0);
        rd(2'd1, d); chk("R1 period low", int'(d), 0);
        rd(2'd2, d); chk("R1 period high", int'(d), 0);
        rd(2'd0, d); chk("R1 status", int'(d), 0);

        // R5 zero period blocks start
        wr(2'd0, 8'h01);
        rd(2'd0, d); chk("R5 running bit", int'(d[0]), 0);
        count_pulses(30, n); chk("R5 pulses", n, 0);

        // R3 / R2 table walk in retriggerable internal-clock mode
        wr(2'd0, 8'h06);
        wr(2'd0, 8'h07);
        foreach (PERIODS[k]) begin
            wr(2'd1, PERIODS[k][7:0]);
            wr(2'd2, PERIODS[k][15:8]);
            wr(2'd0, 8'h0B);
            wr(2'd0, 8'h01);
            wait_pulse(int'(PERIODS[k]) + 5, n); chk("R3 first gap", n, int'(PERIODS[k]));
            wait_pulse(int'(PERIODS[k]) + 5, n); chk("R3 second gap", n, int'(PERIODS[k]));
            rd(2'd1, d); chk("R2 low readback", int'(d), int'(PERIODS[k][7:0]));
            rd(2'd2, d); chk("R2 high readback", int'(d), int'(PERIODS[k][15:8]));
            wr(2'd0, 8'h02);
        end

        // R12 unknown codes
        rd(2'd0, s0);
        wr(2'd0, 8'h0F);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h0C);
        rd(2'd0, s1); chk("R12 status unchanged", int'(s1), int'(s0));

        // R4 single shot, irq disabled
        wr(2'd1, 8'd4); wr(2'd2, 8'd0);
        wr(2'd0, 8'h05);
        wr(2'd0, 8'h04);
        wr(2'd0, 8'h0B);
        wr(2'd0, 8'h01);
        wait_pulse(10, n); chk("R4 single gap", n, 4);
        chk("R6 no irq when disabled", int'(irq), 0);
        count_pulses(30, n); chk("R4 no further pulse", n, 0);
        rd(2'd0, d); chk("R4 running cleared", int'(d[0]), 0);

        // R6 / R7 interrupt
        wr(2'd0, 8'h03);
        wr(2'd0, 8'h01);
        wait_pulse(10, n); chk("R6 gap", n, 4);
        chk("R6 irq set with pulse", int'(irq), 1);
        rd(2'd0, d); chk("R6 pending bit", int'(d[5]), 1);
        chk("R7 irq cleared by read", int'(irq), 0);

        // R8 routing
        wr(2'd0, 8'h0A);
        wr(2'd0, 8'h01);
        wait_pulse(10, n); chk("R8 pin off when unrouted", int'(pin0_drive), 0);
        wr(2'd0, 8'h09);
        wr(2'd0, 8'h01);
        wait_pulse(10, n); chk("R8 pin with pulse", int'(pin0_drive), 1);
        @(negedge clk); chk("R8 pin one cycle", int'(pin0_drive), 0);
        rd(2'd0, d); chk("R8 route bit", int'(d[4]), 1);

        // R10 reset-timer command
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h06);
        wr(2'd0, 8'h01);
        repeat (5) @(negedge clk);
        wr(2'd0, 8'h0B);
        rd(2'd0, d); chk("R10 running cleared", int'(d[0]), 0);
        rd(2'd1, d); chk("R10 period kept", int'(d), 16);
        count_pulses(40, n); chk("R10 no pulses", n, 0);
        wr(2'd0, 8'h01);
        wait_pulse(30, n); chk("R10 full reload", n, 16);

        // R11 stop
        wr(2'd0, 8'h02);
        count_pulses(40, n); chk("R11 halted", n, 0);
        rd(2'd0, d); chk("R11 running bit", int'(d[0]), 0);

        // R9 external clock
        wr(2'd1, 8'd3);
        wr(2'd0, 8'h08);
        wr(2'd0, 8'h0B);
        wr(2'd0, 8'h01);
        rd(2'd0, d); chk("R9 ext bit", int'(d[3]), 1);
        count_pulses(40, n); chk("R9 idle pin", n, 0);
        ext_train(7, n); chk("R9 pulses per edges", n, 2);
        wr(2'd0, 8'h07);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule